// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside instruction fetch and is looked up in the same cycle as instruction memory. The fetch address is split into an index and a tag. A direct-mapped table of entries returns a hit when the indexed entry is valid and its stored tag equals the tag of the fetch address. A hit means the instruction is a known branch that is predicted taken, and the block supplies that branch's stored target. The block also presents the address fetch should use next: the stored target on a hit, or the fetch address plus one instruction on a miss. All of these outputs are combinational, so a hit steers fetch in the following cycle without a stall.

When a branch executes, the pipeline reports it on the resolution port. The report carries the branch address, the actual direction and target, and the prediction that fetch acted on. The block compares the prediction with the outcome. A taken branch that was not predicted is written into the table. A predicted-taken branch whose outcome disagrees is removed from the table. In both cases the block raises a flush in the same cycle, together with the address where fetch must restart. Table writes take effect at the next clock edge.

Top module: `btb_top`

## Requirements
- R1: Reset clears every entry; after reset every lookup misses until a taken branch is resolved.
- R2: A lookup hits only when the entry at index (fetch_pc / INST_BYTES) mod ENTRIES is valid and its stored tag (fetch_pc / (INST_BYTES*ENTRIES)) equals that of fetch_pc; pred_target is zero on a miss.
- R3: In the same cycle, next_pc equals pred_target on a hit and fetch_pc + INST_BYTES on a miss.
- R4: A resolution with res_taken=1 and res_pred_taken=0 writes the branch address and res_target into the table, so the next cycle's lookup of that address hits with that target.
- R5: A resolution with res_taken=0 and res_pred_taken=0 writes nothing and raises no flush.
- R6: flush is raised in the resolution cycle exactly when the direction differs, or when both directions are taken and the targets differ. flush_pc is then res_target if res_taken=1, else res_pc + INST_BYTES.
- R7: A mispredicted resolution with res_pred_taken=1 removes the indexed entry if its stored tag matches res_pc. An entry at that index with a different tag is kept.
- R8: A write to the index being looked up is invisible in that cycle and visible in the next.
- R9: A correctly predicted taken branch (same target) raises no flush and leaves its entry in place.
- R10: Allocating an address that shares an index with a stored entry replaces that entry, so the older address then misses.
- R11: flush stays low in every cycle where res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| pred_hit | output | 1 | Known branch, predicted taken |
| pred_target | output | PC_W | Stored target on a hit, zero otherwise |
| next_pc | output | PC_W | Address fetch should use next |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | PC_W | Actual target address |
| res_pred_taken | input | 1 | Prediction fetch used for this branch |
| res_pred_target | input | PC_W | Target fetch used for this branch |
| flush | output | 1 | Kill wrongly fetched work and redirect |
| flush_pc | output | PC_W | Restart address when flush is high, zero otherwise |

## Verification
The checker watches several rules on every cycle. It checks the next_pc selection and that flush stays quiet without a resolution. It checks that flush follows a direction disagreement and that a correct taken prediction never flushes. It also checks that an unpredicted taken branch hits in the cycle after it is written, that a removed branch misses afterwards, and that the table is empty right after reset. Other behaviours show up only in the bench's scenarios, which compare against a behavioural table model on every clock. These are the same-cycle invisibility of a write, the replacement of an aliasing address, and the survival of a differently tagged entry when a stale branch is removed.

// File: rtl/btb_pkg.sv
package btb_pkg;
   typedef enum logic [1:0] {
      TBL_KEEP  = 2'd0,
      TBL_FILL  = 2'd1,
      TBL_EVICT = 2'd2
   } tbl_op_e;

   function automatic int unsigned log2c(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 6,
   parameter int unsigned OFF_W = 2
) (
   input  logic [PC_W-1:0]             addr,
   output logic [IDX_W-1:0]            idx,
   output logic [PC_W-IDX_W-OFF_W-1:0] tag
);
   localparam int unsigned TAG_LO = IDX_W + OFF_W;

   always_comb begin
      idx = addr[TAG_LO-1:OFF_W];
      tag = addr[PC_W-1:TAG_LO];
   end
endmodule

// File: rtl/btb_store.sv
module btb_store
   import btb_pkg::*;
#(
   parameter int unsigned ENTRIES = 64,
   parameter int unsigned TAG_W   = 24,
   parameter int unsigned TGT_W   = 32,
   localparam int unsigned IDX_W  = log2c(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic [TGT_W-1:0] rd_tgt,
   input  tbl_op_e          wr_op,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [TGT_W-1:0] wr_tgt
);
   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [TGT_W-1:0]   tgt_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      logic fill;
      logic evict;

      always_comb begin
         sel   = (wr_idx == IDX_W'(e));
         fill  = sel && (wr_op == TBL_FILL);
         evict = sel && (wr_op == TBL_EVICT) && (tag_q[e] == wr_tag);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[e] <= 1'b0;
         end else if (fill) begin
            valid_q[e] <= 1'b1;
         end else if (evict) begin
            valid_q[e] <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (fill) begin
            tag_q[e] <= wr_tag;
            tgt_q[e] <= wr_tgt;
         end
      end
   end

   always_comb begin
      rd_valid = valid_q[rd_idx];
      rd_tag   = tag_q[rd_idx];
      rd_tgt   = tgt_q[rd_idx];
   end
endmodule

// File: rtl/btb_resolver.sv
module btb_resolver
   import btb_pkg::*;
#(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned INST_BYTES = 4
) (
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_pred_taken,
   input  logic [PC_W-1:0] res_pred_target,
   output logic            flush,
   output logic [PC_W-1:0] flush_pc,
   output tbl_op_e         op
);
   logic dir_miss;
   logic tgt_miss;
   logic wrong;

   always_comb begin
      dir_miss = (res_pred_taken != res_taken);
      tgt_miss = res_pred_taken && res_taken && (res_pred_target != res_target);
      wrong    = dir_miss || tgt_miss;
      flush    = res_valid && wrong;
      flush_pc = '0;
      if (flush) flush_pc = res_taken ? res_target : (res_pc + PC_W'(INST_BYTES));
      op = TBL_KEEP;
      if (res_valid) begin
         if (res_taken && !res_pred_taken) op = TBL_FILL;
         else if (res_pred_taken && wrong) op = TBL_EVICT;
      end
   end
endmodule

// File: rtl/btb_top.sv
module btb_top
   import btb_pkg::*;
#(
   parameter int unsigned PC_W          = 32,
   parameter int unsigned ENTRIES       = 64,
   parameter int unsigned INST_BYTES    = 4,
   parameter bit          ALIGN_TARGETS = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_hit,
   output logic [PC_W-1:0] pred_target,
   output logic [PC_W-1:0] next_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic            res_pred_taken,
   input  logic [PC_W-1:0] res_pred_target,
   output logic            flush,
   output logic [PC_W-1:0] flush_pc
);
   localparam int unsigned IDX_W = log2c(ENTRIES);
   localparam int unsigned OFF_W = log2c(INST_BYTES);
   localparam int unsigned TAG_W = PC_W - IDX_W - OFF_W;
   localparam int unsigned TGT_W = ALIGN_TARGETS ? (PC_W - OFF_W) : PC_W;

   if ((32'd1 << IDX_W) != ENTRIES || ENTRIES < 2) begin : g_bad_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if ((32'd1 << OFF_W) != INST_BYTES || INST_BYTES < 2) begin : g_bad_inst
      $error("INST_BYTES must be a power of two, at least 2");
   end
   if (PC_W <= IDX_W + OFF_W) begin : g_bad_pc
      $error("PC_W too narrow for index and offset");
   end

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag, rd_tag;
   logic [TGT_W-1:0] rd_tgt, wr_tgt;
   logic             rd_valid;
   logic [PC_W-1:0]  rd_target;
   tbl_op_e          op;

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_lk (
      .addr(fetch_pc), .idx(lk_idx), .tag(lk_tag)
   );

   btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split_wr (
      .addr(res_pc), .idx(wr_idx), .tag(wr_tag)
   );

   if (ALIGN_TARGETS) begin : g_tgt_aligned
      always_comb begin
         wr_tgt    = res_target[PC_W-1:OFF_W];
         rd_target = {rd_tgt, {OFF_W{1'b0}}};
      end
   end else begin : g_tgt_full
      always_comb begin
         wr_tgt    = res_target;
         rd_target = rd_tgt;
      end
   end

   btb_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(TGT_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_tgt(rd_tgt),
      .wr_op(op), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt)
   );

   btb_resolver #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_res (
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_taken(res_pred_taken),
      .res_pred_target(res_pred_target),
      .flush(flush), .flush_pc(flush_pc), .op(op)
   );

   always_comb begin
      pred_hit    = rd_valid && (rd_tag == lk_tag);
      pred_target = pred_hit ? rd_target : '0;
      next_pc     = pred_hit ? rd_target : (fetch_pc + PC_W'(INST_BYTES));
   end
endmodule

// File: rtl/btb_chk.sv
module btb_chk #(
   parameter int unsigned PC_W       = 32,
   parameter int unsigned INST_BYTES = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_hit,
   input logic [PC_W-1:0] pred_target,
   input logic [PC_W-1:0] next_pc,
   input logic            res_valid,
   input logic [PC_W-1:0] res_pc,
   input logic            res_taken,
   input logic            res_pred_taken,
   input logic [PC_W-1:0] res_target,
   input logic [PC_W-1:0] res_pred_target,
   input logic            flush
);
   // R1
   empty_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !pred_hit);

   // R3
   next_pc_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      next_pc == (pred_hit ? pred_target : fetch_pc + PC_W'(INST_BYTES)));

   // R11
   quiet_without_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !flush);

   // R6
   dir_wrong_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && (res_taken != res_pred_taken)) |-> flush);

   // R9
   right_taken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && res_pred_taken && res_target == res_pred_target) |-> !flush);

   // R4
   fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && !res_pred_taken) |=>
         (fetch_pc != $past(res_pc) || pred_hit));

   // R7
   evict_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_pred_taken && !res_taken) |=>
         (fetch_pc != $past(res_pc) || !pred_hit));
endmodule

bind btb_top btb_chk #(.PC_W(PC_W), .INST_BYTES(INST_BYTES)) u_chk (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
   .pred_target(pred_target), .next_pc(next_pc), .res_valid(res_valid),
   .res_pc(res_pc), .res_taken(res_taken), .res_pred_taken(res_pred_taken),
   .res_target(res_target), .res_pred_target(res_pred_target), .flush(flush)
);

// File: tb/sim_btb_top.sv
`timescale 1ns/1ps
module sim_btb_top;
   localparam int PC_W = 32;
   localparam int ENTRIES = 64;
   localparam int INST = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic pred_hit, flush;
   logic [31:0] pred_target, next_pc, flush_pc;
   logic res_valid = 1'b0, res_taken = 1'b0, res_pred_taken = 1'b0;
   logic [31:0] res_pc = '0, res_target = '0, res_pred_target = '0;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // behavioural table model: one slot per index, holding the full branch address
   bit          m_valid [ENTRIES];
   logic [31:0] m_pc    [ENTRIES];
   logic [31:0] m_tgt   [ENTRIES];

   always #4 clk = ~clk;

   btb_top #(.PC_W(PC_W), .ENTRIES(ENTRIES), .INST_BYTES(INST)) u0 (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
      .pred_target(pred_target), .next_pc(next_pc), .res_valid(res_valid),
      .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
      .res_pred_taken(res_pred_taken), .res_pred_target(res_pred_target),
      .flush(flush), .flush_pc(flush_pc)
   );

   function automatic int slot(input logic [31:0] a);
      return int'((a / INST) % ENTRIES);
   endfunction

   function automatic bit same_line(input logic [31:0] a, input logic [31:0] b);
      return (a / INST) == (b / INST);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic cyc(input string req, input logic [31:0] fpc, input bit rv,
                      input logic [31:0] rpc, input bit tk, input logic [31:0] tg,
                      input bit ptk, input logic [31:0] ptg);
      bit e_hit, e_fl, wrong;
      logic [31:0] e_tgt, e_fpc;
      int s;
      @(negedge clk);
      fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = tk;
      res_target = tg; res_pred_taken = ptk; res_pred_target = ptg;
      #1;
      s = slot(fpc);
      e_hit = m_valid[s] && same_line(m_pc[s], fpc);
      e_tgt = e_hit ? m_tgt[s] : 32'h0;
      chk(req, "pred_hit", {31'b0, pred_hit}, {31'b0, e_hit});
      chk(req, "pred_target", pred_target, e_tgt);
      chk(req, "next_pc", next_pc, e_hit ? e_tgt : fpc + INST);
      wrong = (tk != ptk) || (tk && ptk && tg != ptg);
      e_fl  = rv && wrong;
      e_fpc = e_fl ? (tk ? tg : rpc + INST) : 32'h0;
      if (!rv) chk("R11", "flush idle", {31'b0, flush}, 32'h0);
      else     chk(req, "flush", {31'b0, flush}, {31'b0, e_fl});
      chk(req, "flush_pc", flush_pc, e_fpc);
      @(posedge clk);
      if (rv) begin
         s = slot(rpc);
         if (tk && !ptk) begin
            m_valid[s] = 1'b1; m_pc[s] = rpc; m_tgt[s] = tg;
         end else if (ptk && wrong && m_valid[s] && same_line(m_pc[s], rpc)) begin
            m_valid[s] = 1'b0;
         end
      end
   endtask

   task automatic look(input string req, input logic [31:0] fpc);
      cyc(req, fpc, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 32'h0);
   endtask

   initial begin
      logic [31:0] A, B, C, D;
      A = 32'h0000_1000; B = A + ENTRIES * INST; C = 32'h0000_2044; D = 32'h0000_3080;
      for (int i = 0; i < ENTRIES; i++) m_valid[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1: empty after reset
      look("R1", A); look("R1", C); look("R1", 32'hFFFF_FFFC);
      // R5: not taken, not predicted: no write, no flush
      cyc("R5", C, 1'b1, A, 1'b0, 32'h0, 1'b0, 32'h0);
      look("R5", A);
      // R4 + R8: fill A->0x5000 while looking up A (old contents), then hit
      cyc("R8", A, 1'b1, A, 1'b1, 32'h0000_5000, 1'b0, 32'h0);
      look("R4", A);
      look("R2", A + 1);      // same instruction word, hits
      look("R2", A + INST);   // other index, misses
      // R9: correct taken prediction, entry kept
      cyc("R9", A, 1'b1, A, 1'b1, 32'h0000_5000, 1'b1, 32'h0000_5000);
      look("R9", A);
      // R10: alias B replaces A
      cyc("R10", B, 1'b1, B, 1'b1, 32'h0000_6000, 1'b0, 32'h0);
      look("R10", A); look("R10", B);
      // R7: stale A removal keeps B; then B removal
      cyc("R7", B, 1'b1, A, 1'b0, 32'h0, 1'b1, 32'h0000_5000);
      look("R7", B);
      cyc("R7", B, 1'b1, B, 1'b0, 32'h0, 1'b1, 32'h0000_6000);
      look("R7", B);
      // R6: wrong target flushes to actual target and removes entry
      cyc("R6", D, 1'b1, C, 1'b1, 32'h0000_7000, 1'b0, 32'h0);
      look("R6", C);
      cyc("R6", C, 1'b1, C, 1'b1, 32'h0000_7100, 1'b1, 32'h0000_7000);
      look("R6", C);
      // R3: mixed traffic over a small address set
      for (int i = 0; i < 400; i++) begin
         logic [31:0] pa, pb;
         bit rv, tk, ptk;
         pa = 32'h0000_1000 + (($urandom % 8) * ENTRIES * INST) + (($urandom % 4) * INST);
         pb = 32'h0000_1000 + (($urandom % 8) * ENTRIES * INST) + (($urandom % 4) * INST);
         rv = ($urandom % 3) != 0; tk = $urandom % 2; ptk = $urandom % 2;
         cyc("R3", pa, rv, pb, tk, 32'h0000_9000 + (($urandom % 3) * 16),
             ptk, 32'h0000_9000 + (($urandom % 3) * 16));
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule